// File: doc/BRIEF.md
# Dual-Seed CRC16 Engine

This block computes a 16-bit cyclic redundancy check over a packet one byte at a time. In transmit mode it runs over the packet bytes given to it, normally the length byte and the payload. After the last byte it emits the two check bytes, low byte first, on a byte output that is valid for exactly two cycles. The starting value is either a programmable 16-bit seed or zero, picked per packet by a select input that is sampled together with the seed when the packet starts.

In receive mode two accumulators run side by side over the same bytes. One starts from the programmed seed and the other from zero. The two check bytes that follow the last data byte are gathered and compared against both results. A one-cycle status pulse then reports a seeded match, a zero-seed match, both, or a failure. A start strobe reloads both accumulators in the cycle it is given, even in the middle of a packet. That lets the surrounding framer abandon a packet and begin the next one at once.

Top module: `crc16_dual_seed`

## Requirements
- R1: The check value uses the polynomial x^16+x^15+x^2+1 in reflected form (0xA001). Each byte is taken least significant bit first, with no final inversion. In transmit mode `crcOutValid` is high in exactly the two cycles after the cycle that accepts the last data byte. `crcOutByte` carries check bits [7:0] in the first of those cycles and [15:8] in the second.
- R2: In transmit mode the seed is `seedValue` when `seedSelZero` is 0 and all zeros when it is 1. Both inputs are sampled in the start cycle. Changes to `seedValue`, `seedSelZero` or `modeTx` after the start cycle have no effect on that packet.
- R3: In receive mode the first byte after the last data byte is taken as check bits [7:0] and the next as bits [15:8]. `crcOkSeed` pulses when the received value equals the check over the data from `seedValue`. `crcOkZero` pulses when it equals the check from a zero seed. Both pulse together when both match.
- R4: `crcFail` pulses when the received value matches neither check. All three status outputs are high only in the single cycle after the second check byte is accepted, and are low at every other time.
- R5: A start strobe reloads both accumulators in that same cycle, mid-packet included. If `byteValid` is high in the start cycle, that byte is the packet's first byte.
- R6: Cycles with `byteValid` low leave the packet state unchanged. This holds between data bytes and between the two received check bytes.
- R7: Bytes and last strobes given outside a packet, after the packet has completed and before the next start, produce no check output and no status.
- R8: While `rstN` is low and in the cycle after its release, `crcOutValid`, `crcOkSeed`, `crcOkZero` and `crcFail` are 0.
- R9: During the two transmit output cycles, `byteValid` and `byteIn` do not alter the emitted check bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| modeTx | input | 1 | 1 = transmit, 0 = receive; sampled at start |
| startPulse | input | 1 | Begin a packet; reloads both accumulators |
| byteValid | input | 1 | `byteIn` carries a byte this cycle |
| byteIn | input | 8 | Packet byte, or received check byte |
| lastPulse | input | 1 | With `byteValid`, marks the last data byte |
| seedValue | input | 16 | Programmable seed, sampled at start |
| seedSelZero | input | 1 | Transmit seed select: 1 = zero seed; sampled at start |
| crcOutValid | output | 1 | Transmit check byte valid |
| crcOutByte | output | 8 | Transmit check byte, low byte first |
| crcOkSeed | output | 1 | Received check matched the seeded value (pulse) |
| crcOkZero | output | 1 | Received check matched the zero-seed value (pulse) |
| crcFail | output | 1 | Received check matched neither (pulse) |

## Verification
A wrong accumulator bit cannot be seen until the packet ends. It shows as a wrong check byte in the two cycles after the last data byte, or as a wrong status pulse one cycle after the second received check byte. Known-answer packets for both seeds pin down bit order and byte order. A control state that is off by one shows at once as output bytes in the wrong cycle or a status pulse in the wrong place. The bench checks the output cycle by cycle around every packet end, and after a restart, after gaps and after stray bytes.

// File: rtl/crc16_pkg.sv
package crc16_pkg;

  localparam int CRC_W = 16;
  localparam int BYTE_W = 8;
  localparam logic [CRC_W-1:0] POLY_REFL_DEFAULT = 16'hA001;

  typedef struct packed {
    logic load;    // reload both accumulators
    logic accum;   // fold byteIn into both accumulators
    logic capLo;   // store received low check byte
    logic cmp;     // compare received check with both accumulators
    logic emitLo;  // present low check byte
    logic emitHi;  // present high check byte
  } crcStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DATA,
    ST_RX_LO,
    ST_RX_HI,
    ST_TX_LO,
    ST_TX_HI
  } crcState_t;

  // One byte through the reflected shift register, LSB first.
  function automatic logic [CRC_W-1:0] crcStep(input logic [CRC_W-1:0] crcIn,
                                               input logic [BYTE_W-1:0] dataIn,
                                               input logic [CRC_W-1:0] polyRefl);
    logic [CRC_W-1:0] c;
    logic fb;
    c = crcIn;
    for (int i = 0; i < BYTE_W; i++) begin
      fb = c[0] ^ dataIn[i];
      c = c >> 1;
      if (fb) c = c ^ polyRefl;
    end
    return c;
  endfunction

endpackage

// File: rtl/crc16_ctrl.sv
module crc16_ctrl
  import crc16_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       modeTx,
  input  logic       startPulse,
  input  logic       byteValid,
  input  logic       lastPulse,
  output crcStrobe_t str
);

  crcState_t st, stNext;
  logic modeReg, modeNext;

  always_comb begin
    stNext = st;
    modeNext = modeReg;
    str = '0;
    str.emitLo = (st == ST_TX_LO);
    str.emitHi = (st == ST_TX_HI);
    if (startPulse) begin
      str.load = 1'b1;
      str.accum = byteValid;
      modeNext = modeTx;
      if (byteValid && lastPulse) stNext = modeTx ? ST_TX_LO : ST_RX_LO;
      else stNext = ST_DATA;
    end else begin
      case (st)
        ST_DATA: begin
          if (byteValid) begin
            str.accum = 1'b1;
            if (lastPulse) stNext = modeReg ? ST_TX_LO : ST_RX_LO;
          end
        end
        ST_RX_LO: begin
          if (byteValid) begin
            str.capLo = 1'b1;
            stNext = ST_RX_HI;
          end
        end
        ST_RX_HI: begin
          if (byteValid) begin
            str.cmp = 1'b1;
            stNext = ST_IDLE;
          end
        end
        ST_TX_LO: stNext = ST_TX_HI;
        ST_TX_HI: stNext = ST_IDLE;
        default:  stNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st <= ST_IDLE;
      modeReg <= 1'b0;
    end else begin
      st <= stNext;
      modeReg <= modeNext;
    end
  end

  // R1: the low output byte is always followed by the high one unless restarted
  p_lo_then_hi_r1: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_TX_LO && !startPulse) |=> (st == ST_TX_HI));

  // R7: outside a packet nothing is accumulated or compared
  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_IDLE && !startPulse) |-> (!str.accum && !str.cmp && !str.capLo));

  // R9: input bytes never reach the accumulators while check bytes are emitted
  p_emit_no_accum_r9: assert property (@(posedge clk) disable iff (!rstN)
    ((st == ST_TX_LO || st == ST_TX_HI) && !startPulse) |-> !str.accum);

endmodule

// File: rtl/crc16_dp.sv
module crc16_dp
  import crc16_pkg::*;
#(
  parameter logic [CRC_W-1:0] POLY_REFL = POLY_REFL_DEFAULT
) (
  input  logic              clk,
  input  logic              rstN,
  input  crcStrobe_t        str,
  input  logic [BYTE_W-1:0] byteIn,
  input  logic [CRC_W-1:0]  seedValue,
  input  logic              seedSelZero,
  output logic              crcOutValid,
  output logic [BYTE_W-1:0] crcOutByte,
  output logic              crcOkSeed,
  output logic              crcOkZero,
  output logic              crcFail
);

  localparam int NUM_ACC = 2;           // index 0: programmed seed, 1: zero seed

  logic [CRC_W-1:0] acc [NUM_ACC];
  logic [CRC_W-1:0] loadVal [NUM_ACC];
  logic [BYTE_W-1:0] rxLo;
  logic selZeroReg;
  logic [CRC_W-1:0] rxWord, txWord;

  assign loadVal[0] = seedValue;
  assign loadVal[1] = '0;

  for (genvar k = 0; k < NUM_ACC; k++) begin : g_acc
    logic [CRC_W-1:0] base;
    assign base = str.load ? loadVal[k] : acc[k];
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) acc[k] <= '0;
      else if (str.accum) acc[k] <= crcStep(base, byteIn, POLY_REFL);
      else if (str.load) acc[k] <= base;
    end
  end

  assign rxWord = {byteIn, rxLo};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxLo <= '0;
      selZeroReg <= 1'b0;
      crcOkSeed <= 1'b0;
      crcOkZero <= 1'b0;
      crcFail <= 1'b0;
    end else begin
      if (str.load) selZeroReg <= seedSelZero;
      if (str.capLo) rxLo <= byteIn;
      crcOkSeed <= str.cmp && (rxWord == acc[0]);
      crcOkZero <= str.cmp && (rxWord == acc[1]);
      crcFail <= str.cmp && (rxWord != acc[0]) && (rxWord != acc[1]);
    end
  end

  assign txWord = selZeroReg ? acc[1] : acc[0];
  assign crcOutValid = str.emitLo | str.emitHi;
  assign crcOutByte = str.emitHi ? txWord[CRC_W-1:BYTE_W] : txWord[BYTE_W-1:0];

  // R4: a failure never coincides with a match
  p_fail_excl_r4: assert property (@(posedge clk) disable iff (!rstN)
    crcFail |-> (!crcOkSeed && !crcOkZero));

  // R4: status is a single-cycle pulse
  p_status_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    (crcOkSeed || crcOkZero || crcFail) |=> !(crcOkSeed || crcOkZero || crcFail));

  // R5: a bare reload leaves the seed and zero in the accumulators
  p_load_seed_r5: assert property (@(posedge clk) disable iff (!rstN)
    (str.load && !str.accum) |=> (acc[1] == '0 && acc[0] == $past(seedValue)));

endmodule

// File: rtl/crc16_dual_seed.sv
module crc16_dual_seed
  import crc16_pkg::*;
#(
  parameter logic [CRC_W-1:0] POLY_REFL = POLY_REFL_DEFAULT
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeTx,
  input  logic              startPulse,
  input  logic              byteValid,
  input  logic [BYTE_W-1:0] byteIn,
  input  logic              lastPulse,
  input  logic [CRC_W-1:0]  seedValue,
  input  logic              seedSelZero,
  output logic              crcOutValid,
  output logic [BYTE_W-1:0] crcOutByte,
  output logic              crcOkSeed,
  output logic              crcOkZero,
  output logic              crcFail
);

  crcStrobe_t str;

  crc16_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .modeTx     (modeTx),
    .startPulse (startPulse),
    .byteValid  (byteValid),
    .lastPulse  (lastPulse),
    .str        (str)
  );

  crc16_dp #(.POLY_REFL(POLY_REFL)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .str         (str),
    .byteIn      (byteIn),
    .seedValue   (seedValue),
    .seedSelZero (seedSelZero),
    .crcOutValid (crcOutValid),
    .crcOutByte  (crcOutByte),
    .crcOkSeed   (crcOkSeed),
    .crcOkZero   (crcOkZero),
    .crcFail     (crcFail)
  );

endmodule

// File: tb/crc16_dual_seed_tb.sv
module crc16_dual_seed_tb;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic modeTx = 1'b0, startPulse = 1'b0, byteValid = 1'b0, lastPulse = 1'b0;
  logic [7:0] byteIn = 8'h00;
  logic [15:0] seedValue = 16'h0000;
  logic seedSelZero = 1'b0;
  logic crcOutValid, crcOkSeed, crcOkZero, crcFail;
  logic [7:0] crcOutByte;

  int nChecks = 0;
  int nFail = 0;
  logic [15:0] txGot;

  always #10 clk = ~clk;  // 50 MHz

  crc16_dual_seed u_dut (
    .clk(clk), .rstN(rstN), .modeTx(modeTx), .startPulse(startPulse),
    .byteValid(byteValid), .byteIn(byteIn), .lastPulse(lastPulse),
    .seedValue(seedValue), .seedSelZero(seedSelZero),
    .crcOutValid(crcOutValid), .crcOutByte(crcOutByte),
    .crcOkSeed(crcOkSeed), .crcOkZero(crcOkZero), .crcFail(crcFail)
  );

  // Stimulus table: mode 1 = transmit; kind 0 = send seeded check, 1 = zero-seed check, 2 = corrupted
  localparam int NV = 8;
  localparam logic        V_MODE [NV] = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1};
  localparam logic        V_SELZ [NV] = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1};
  localparam logic [15:0] V_SEED [NV] = '{16'hFFFF, 16'hBEEF, 16'h1D0F, 16'hC3A5,
                                          16'hC3A5, 16'h7E01, 16'h0000, 16'h0000};
  localparam int          V_LEN  [NV] = '{9, 9, 16, 12, 12, 5, 3, 1};
  localparam logic [7:0]  V_BASE [NV] = '{8'h31, 8'h31, 8'h00, 8'h40, 8'h40, 8'hF0, 8'hAA, 8'hFF};
  localparam logic [7:0]  V_STEP [NV] = '{8'h01, 8'h01, 8'h11, 8'h07, 8'h07, 8'h03, 8'h55, 8'h00};
  localparam int          V_GAP  [NV] = '{0, 0, 1, 0, 2, 0, 1, 0};
  localparam int          V_KIND [NV] = '{0, 0, 0, 0, 1, 2, 0, 0};

  function automatic logic [7:0] payByte(input logic [7:0] base, input logic [7:0] step, input int j);
    return base + 8'(j) * step;
  endfunction

  // Reference model written from R1: reflected 0x8005, LSB first, no inversion
  function automatic logic [15:0] refCrc(input logic [15:0] seed, input int n,
                                         input logic [7:0] base, input logic [7:0] step);
    logic [15:0] c;
    logic [7:0] b;
    c = seed;
    for (int j = 0; j < n; j++) begin
      b = payByte(base, step, j);
      for (int k = 0; k < 8; k++) begin
        if (c[0] ^ b[k]) c = (c >> 1) ^ 16'hA001;
        else c = c >> 1;
      end
    end
    return c;
  endfunction

  task automatic checkEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One clock: inputs applied now, returns at the following falling edge
  task automatic cyc(input logic s, input logic v, input logic l, input logic [7:0] b);
    startPulse = s; byteValid = v; lastPulse = l; byteIn = b;
    @(negedge clk);
    startPulse = 1'b0; byteValid = 1'b0; lastPulse = 1'b0; byteIn = 8'h00;
  endtask

  task automatic statusIs(input string tag, input logic s, input logic z, input logic f);
    checkEq({tag, " crcOkSeed"}, 32'(crcOkSeed), 32'(s));
    checkEq({tag, " crcOkZero"}, 32'(crcOkZero), 32'(z));
    checkEq({tag, " crcFail"}, 32'(crcFail), 32'(f));
  endtask

  task automatic runTx(input logic selZ, input logic [15:0] seed, input int n,
                       input logic [7:0] base, input logic [7:0] step, input int gap,
                       input bit startWithByte, input bit junk, input string tag);
    logic [15:0] exp;
    int first;
    exp = selZ ? refCrc(16'h0000, n, base, step) : refCrc(seed, n, base, step);
    modeTx = 1'b1; seedSelZero = selZ; seedValue = seed;
    if (startWithByte) begin
      cyc(1'b1, 1'b1, n == 1, payByte(base, step, 0));
      first = 1;
    end else begin
      cyc(1'b1, 1'b0, 1'b0, 8'h00);
      first = 0;
    end
    // R2: disturb the sampled inputs after the start cycle
    seedValue = ~seed; seedSelZero = ~selZ; modeTx = 1'b0;
    for (int j = first; j < n; j++) begin
      cyc(1'b0, 1'b1, j == n - 1, payByte(base, step, j));
      if (j < n - 1) for (int g = 0; g < gap; g++) cyc(1'b0, 1'b0, 1'b0, 8'h00);
    end
    checkEq({tag, " R1 first output valid"}, 32'(crcOutValid), 32'd1);
    checkEq({tag, " R1 R2 low check byte"}, 32'(crcOutByte), 32'(exp[7:0]));
    txGot[7:0] = crcOutByte;
    cyc(1'b0, junk, 1'b0, 8'hA5);
    checkEq({tag, " R1 second output valid"}, 32'(crcOutValid), 32'd1);
    checkEq({tag, " R1 R9 high check byte"}, 32'(crcOutByte), 32'(exp[15:8]));
    txGot[15:8] = crcOutByte;
    cyc(1'b0, junk, 1'b0, 8'h5A);
    checkEq({tag, " R1 output ends after two bytes"}, 32'(crcOutValid), 32'd0);
  endtask

  task automatic runRx(input logic [15:0] seed, input int n, input logic [7:0] base,
                       input logic [7:0] step, input int gap, input int kind, input string tag);
    logic [15:0] cS, cZ, sent;
    cS = refCrc(seed, n, base, step);
    cZ = refCrc(16'h0000, n, base, step);
    sent = (kind == 0) ? cS : (kind == 1) ? cZ : (cS ^ 16'h0010);
    modeTx = 1'b0; seedValue = seed;
    cyc(1'b1, 1'b0, 1'b0, 8'h00);
    seedValue = seed ^ 16'h1234; modeTx = 1'b1;
    for (int j = 0; j < n; j++) begin
      cyc(1'b0, 1'b1, j == n - 1, payByte(base, step, j));
      if (j < n - 1) for (int g = 0; g < gap; g++) cyc(1'b0, 1'b0, 1'b0, 8'h00);
    end
    cyc(1'b0, 1'b1, 1'b1, sent[7:0]);  // lastPulse here must be ignored
    for (int g = 0; g < gap; g++) begin
      cyc(1'b0, 1'b0, 1'b0, 8'h00);
      statusIs({tag, " R6 gap between check bytes"}, 1'b0, 1'b0, 1'b0);
    end
    cyc(1'b0, 1'b1, 1'b0, sent[15:8]);
    statusIs({tag, " R3 R4 status"}, sent == cS, sent == cZ, (sent != cS) && (sent != cZ));
    cyc(1'b0, 1'b0, 1'b0, 8'h00);
    statusIs({tag, " R4 pulse ends"}, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

  initial begin
    // R8: outputs quiet in reset even with activity on the inputs
    startPulse = 1'b1; byteValid = 1'b1; lastPulse = 1'b1; modeTx = 1'b1;
    repeat (3) @(negedge clk);
    checkEq("R8 crcOutValid in reset", 32'(crcOutValid), 32'd0);
    statusIs("R8 in reset", 1'b0, 1'b0, 1'b0);
    startPulse = 1'b0; byteValid = 1'b0; lastPulse = 1'b0;
    rstN = 1'b1;
    @(negedge clk);
    checkEq("R8 crcOutValid after reset", 32'(crcOutValid), 32'd0);
    statusIs("R8 after reset", 1'b0, 1'b0, 1'b0);

    // Table walk: R1 R2 R3 R4 R6 under several patterns
    for (int i = 0; i < NV; i++) begin
      if (V_MODE[i])
        runTx(V_SELZ[i], V_SEED[i], V_LEN[i], V_BASE[i], V_STEP[i], V_GAP[i], 1'b0, 1'b0,
              $sformatf("vec%0d tx", i));
      else
        runRx(V_SEED[i], V_LEN[i], V_BASE[i], V_STEP[i], V_GAP[i], V_KIND[i],
              $sformatf("vec%0d rx", i));
    end

    // R1 known answers over the bytes "123456789"
    runTx(1'b1, 16'hA5A5, 9, 8'h31, 8'h01, 0, 1'b0, 1'b0, "known zero seed");
    checkEq("R1 R2 known answer zero seed", 32'(txGot), 32'h0000BB3D);
    runTx(1'b0, 16'hFFFF, 9, 8'h31, 8'h01, 0, 1'b0, 1'b0, "known ones seed");
    checkEq("R1 R2 known answer seed FFFF", 32'(txGot), 32'h00004B37);

    // R5: restart in mid-packet, the start cycle carrying the first byte
    modeTx = 1'b1; seedValue = 16'h0F0F;
    cyc(1'b1, 1'b0, 1'b0, 8'h00);
    cyc(1'b0, 1'b1, 1'b0, 8'h11);
    cyc(1'b0, 1'b1, 1'b0, 8'h22);
    runTx(1'b0, 16'h5A3C, 6, 8'h81, 8'h13, 0, 1'b1, 1'b0, "R5 restart with byte");

    // R9: bytes offered during emission
    runTx(1'b0, 16'h2468, 4, 8'h09, 8'h21, 0, 1'b0, 1'b1, "R9 junk during emit");

    // R7: stray bytes after a completed packet
    cyc(1'b0, 1'b1, 1'b0, 8'h77);
    cyc(1'b0, 1'b1, 1'b1, 8'h78);
    checkEq("R7 no output after stray last", 32'(crcOutValid), 32'd0);
    cyc(1'b0, 1'b1, 1'b0, 8'h79);
    checkEq("R7 no output second cycle", 32'(crcOutValid), 32'd0);
    cyc(1'b0, 1'b1, 1'b0, 8'h7A);
    statusIs("R7 no status from stray bytes", 1'b0, 1'b0, 1'b0);

    // R5 in receive: abandon a packet, then a clean one must match the seed
    modeTx = 1'b0; seedValue = 16'h3333;
    cyc(1'b1, 1'b1, 1'b0, 8'hEE);
    cyc(1'b0, 1'b1, 1'b0, 8'hDD);
    runRx(16'h9C41, 7, 8'h10, 8'h0B, 0, 0, "R5 rx restart");

    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

endmodule